// File: doc/BRIEF.md
# Power-Management Event and Timer Unit

This unit holds the fixed power-management registers of a PC-style chipset. A free-running timer is derived from the system clock by a fractional accumulator, so its count rate tracks a nominal 3.579545 MHz for any clock frequency. Three 16-bit registers sit beside it: an event status register whose bits are cleared by writing ones, an event enable register, and a control register. Software reaches them through a simple register port. The timer is read as a 32-bit value.

The unit drives a level-sensitive system control interrupt (SCI). The interrupt is high while an enabled event is pending. A sleep request written to the control register produces a one-cycle shutdown or reset request. A one-cycle power-button pulse becomes a pending event if that event is enabled.

A byte-wide power-management command and status port pair is also part of the unit. Two reserved command codes switch the SCI-enable bit. Any command write can raise a one-cycle SMI pulse when the platform allows it.

Top module: `pm_event_unit`

## Requirements
- R1: The timer advances by one on each tick of a fractional accumulator. The accumulator adds `TMR_HZ` per clock and ticks when it reaches `CLK_HZ`. The `TMR_W`-bit count wraps to zero and is read, zero-extended to 32 bits, at offset 0x08.
- R2: Offset 0x00 reads status, 0x02 reads and writes the full enable word, and 0x04 reads control. Every other offset reads zero, and writes to it change nothing.
- R3: Writing a 1 to a status bit clears it and writing 0 leaves it. If a set event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Status bit 0 sets each time the count moves onto a multiple of 2^(`TMR_W`-1). This includes the wrap to zero, so after software clears the bit it sets again at the next such boundary above the count.
- R5: `sci` is high exactly when status and enable share a set bit among positions 0, 5, 8 and 10.
- R6: A `pwr_btn` pulse sets status bit 8 only if enable bit 8 is set.
- R7: A control write stores every bit except bit 13, which always reads 0. Bits 12:10 of the written value give the sleep type.
- R8: A control write with bit 13 set acts on the sleep type. Type 0 raises `shutdown_req` for exactly one cycle, in the next cycle. Type 1 sets status bits 15 and 8 and raises `reset_req` for one cycle. Every other type raises neither request.
- R9: A command-byte write (`apm_sel`=0) of 0xF1 sets control bit 0 and a write of 0xF0 clears it. Any other value leaves control bit 0 unchanged. The command byte reads back on `apm_rdata`, and the status byte (`apm_sel`=1) is a plain read/write byte.
- R10: `smi_pulse` is high for one cycle after a command-byte write made while `smi_en` is high. It never follows a status-byte write, and it never follows a write made while `smi_en` is low.
- R11: After reset all registers, the timer, the accumulator and the pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 6 | Register port byte offset |
| reg_wdata | input | 16 | Register port write data |
| reg_rdata | output | 32 | Register port read data (combinational on `reg_addr`) |
| apm_wr | input | 1 | Command/status byte write strobe |
| apm_sel | input | 1 | 0 selects the command byte, 1 selects the status byte |
| apm_wdata | input | 8 | Command/status byte write data |
| apm_rdata | output | 8 | Selected byte read back |
| smi_en | input | 1 | Platform permission to raise SMI on command writes |
| pwr_btn | input | 1 | One-cycle power-button event |
| sci | output | 1 | Level system control interrupt |
| smi_pulse | output | 1 | One-cycle SMI request |
| shutdown_req | output | 1 | One-cycle soft power-off request |
| reset_req | output | 1 | One-cycle resume reset request |

## Verification
The bench builds the unit with `CLK_HZ`=4, `TMR_HZ`=3 and `TMR_W`=8. With these values the accumulator ticks on three clocks out of four, so the fractional stepping is visible within a handful of cycles. The overflow boundary comes every 128 counts, so both the mid-range boundary and the wrap to zero occur in a few hundred cycles. The run also covers clearing the overflow bit and waiting for it to set again. A behavioural model runs alongside the design and predicts the interrupt level and every pulse output on each clock.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [5:0]  OFS_STS = 6'h00;
  localparam logic [5:0]  OFS_EN  = 6'h02;
  localparam logic [5:0]  OFS_CTL = 6'h04;
  localparam logic [5:0]  OFS_TMR = 6'h08;

  localparam int B_TMR_OVF = 0;
  localparam int B_PWRBTN  = 8;
  localparam int B_WAKE    = 15;
  localparam int B_SLP_STB = 13;
  localparam int B_SCI_EN  = 0;

  localparam logic [15:0] SCI_SRC_MASK = 16'h0521;

  localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
  localparam logic [7:0] APM_ACPI_OFF = 8'hF0;

  typedef enum logic [2:0] {
    SLP_POWER_OFF = 3'd0,
    SLP_RESUME    = 3'd1
  } slp_kind_e;
endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
  parameter int CLK_HZ = 100_000_000,
  parameter int TMR_HZ = 3_579_545
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int ACC_W = $clog2(CLK_HZ + TMR_HZ) + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(TMR_HZ);
  localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_sum = acc_q + STEP;
    tick    = (acc_sum >= WRAP);
    acc_d   = tick ? (acc_sum - WRAP) : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] count,
  output logic             ovf_evt
);
  localparam int LOW_W = TMR_W - 1;

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    ovf_evt = tick && (cnt_inc[LOW_W-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_inc;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pm_apm_port.sv
module pm_apm_port
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apm_wr,
  input  logic       apm_sel,
  input  logic [7:0] apm_wdata,
  input  logic       smi_en,
  output logic [7:0] apm_rdata,
  output logic       acpi_on,
  output logic       acpi_off,
  output logic       smi_pulse
);
  logic [7:0] cmd_q, stat_q;
  logic       cmd_we, stat_we, smi_d, smi_q;

  always_comb begin
    cmd_we   = apm_wr && !apm_sel;
    stat_we  = apm_wr &&  apm_sel;
    acpi_on  = cmd_we && (apm_wdata == APM_ACPI_ON);
    acpi_off = cmd_we && (apm_wdata == APM_ACPI_OFF);
    smi_d    = cmd_we && smi_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= apm_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_we) stat_q <= apm_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_q <= 1'b0;
    else        smi_q <= smi_d;
  end

  assign apm_rdata = apm_sel ? stat_q : cmd_q;
  assign smi_pulse = smi_q;
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        ovf_evt,
  input  logic        pwr_btn,
  input  logic        acpi_on,
  input  logic        acpi_off,
  output logic [15:0] sts,
  output logic [15:0] en,
  output logic [15:0] ctl,
  output logic        sci,
  output logic        shutdown_req,
  output logic        reset_req
);
  logic [15:0] sts_q, en_q, ctl_q;
  logic [15:0] sts_d, ctl_d, sts_set, sts_clr;
  logic        sts_we, en_we, ctl_we, ctl_ce;
  logic        slp_go, shut_d, rst_d, shut_q, rst_q;
  slp_kind_e   slp_kind;

  always_comb begin
    sts_we   = reg_wr && (reg_addr == OFS_STS);
    en_we    = reg_wr && (reg_addr == OFS_EN);
    ctl_we   = reg_wr && (reg_addr == OFS_CTL);
    slp_go   = ctl_we && reg_wdata[B_SLP_STB];
    slp_kind = slp_kind_e'(reg_wdata[12:10]);
    shut_d   = slp_go && (slp_kind == SLP_POWER_OFF);
    rst_d    = slp_go && (slp_kind == SLP_RESUME);

    sts_clr  = sts_we ? reg_wdata : 16'h0000;
    sts_set  = '0;
    sts_set[B_TMR_OVF] = ovf_evt;
    sts_set[B_PWRBTN]  = (pwr_btn && en_q[B_PWRBTN]) || rst_d;
    sts_set[B_WAKE]    = rst_d;
    sts_d    = (sts_q & ~sts_clr) | sts_set;

    ctl_d    = ctl_q;
    if (ctl_we) begin
      ctl_d = reg_wdata;
      ctl_d[B_SLP_STB] = 1'b0;
    end
    if (acpi_on)  ctl_d[B_SCI_EN] = 1'b1;
    if (acpi_off) ctl_d[B_SCI_EN] = 1'b0;
    ctl_ce   = ctl_we || acpi_on || acpi_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      shut_q <= shut_d;
      rst_q  <= rst_d;
    end
  end

  assign sts          = sts_q;
  assign en           = en_q;
  assign ctl          = ctl_q;
  assign sci          = |(sts_q & en_q & SCI_SRC_MASK);
  assign shutdown_req = shut_q;
  assign reset_req    = rst_q;
endmodule

// File: rtl/pm_event_unit.sv
module pm_event_unit
  import pm_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int TMR_HZ = 3_579_545,
  parameter int TMR_W  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        apm_wr,
  input  logic        apm_sel,
  input  logic [7:0]  apm_wdata,
  output logic [7:0]  apm_rdata,
  input  logic        smi_en,
  input  logic        pwr_btn,
  output logic        sci,
  output logic        smi_pulse,
  output logic        shutdown_req,
  output logic        reset_req
);
  localparam int PAD_W = 32 - TMR_W;

  logic             tmr_tick, ovf_evt, acpi_on, acpi_off;
  logic [TMR_W-1:0] tmr_cnt;
  logic [15:0]      sts_q, en_q, ctrl_q;

  pm_tick_gen #(.CLK_HZ(CLK_HZ), .TMR_HZ(TMR_HZ)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick)
  );

  pm_timer #(.TMR_W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick),
    .count(tmr_cnt), .ovf_evt(ovf_evt)
  );

  pm_apm_port apm_i (
    .clk(clk), .rst_n(rst_n), .apm_wr(apm_wr), .apm_sel(apm_sel),
    .apm_wdata(apm_wdata), .smi_en(smi_en), .apm_rdata(apm_rdata),
    .acpi_on(acpi_on), .acpi_off(acpi_off), .smi_pulse(smi_pulse)
  );

  pm_regs regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ovf_evt(ovf_evt), .pwr_btn(pwr_btn),
    .acpi_on(acpi_on), .acpi_off(acpi_off), .sts(sts_q), .en(en_q),
    .ctl(ctrl_q), .sci(sci), .shutdown_req(shutdown_req),
    .reset_req(reset_req)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_STS: reg_rdata = {16'h0000, sts_q};
      OFS_EN:  reg_rdata = {16'h0000, en_q};
      OFS_CTL: reg_rdata = {16'h0000, ctrl_q};
      OFS_TMR: reg_rdata = {{PAD_W{1'b0}}, tmr_cnt};
      default: reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/pm_event_unit_chk.sv
module pm_event_unit_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             apm_wr,
  input logic             apm_sel,
  input logic [7:0]       apm_wdata,
  input logic             smi_en,
  input logic             smi_pulse,
  input logic             shutdown_req,
  input logic             reset_req,
  input logic [15:0]      ctrl_q,
  input logic [TMR_W-1:0] tmr_cnt
);
  // R1: the count only ever holds or steps up by one
  a_r1_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt != $past(tmr_cnt)) |-> (tmr_cnt == $past(tmr_cnt) + 1'b1));

  // R7: the sleep strobe bit is never kept
  a_r7_strobe_not_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[13]);

  // R8: requests are single-cycle and never together
  a_r8_shutdown_single: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  a_r8_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reset_req));

  // R9: enable code sets the SCI-enable control bit
  a_r9_acpi_on: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !apm_sel && apm_wdata == 8'hF1) |=> ctrl_q[0]);
  a_r9_acpi_off: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !apm_sel && apm_wdata == 8'hF0) |=> !ctrl_q[0]);

  // R10: SMI only follows a permitted command write
  a_r10_smi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(apm_wr && !apm_sel && smi_en));
endmodule

bind pm_event_unit pm_event_unit_chk #(.TMR_W(TMR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .apm_wr(apm_wr), .apm_sel(apm_sel),
  .apm_wdata(apm_wdata), .smi_en(smi_en), .smi_pulse(smi_pulse),
  .shutdown_req(shutdown_req), .reset_req(reset_req),
  .ctrl_q(ctrl_q), .tmr_cnt(tmr_cnt)
);

// File: tb/pm_event_unit_tb_top.sv
module pm_event_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 4;
  localparam int TMR_HZ = 3;
  localparam int TMR_W  = 8;
  localparam int TMR_MOD = 1 << TMR_W;
  localparam int HALF    = 1 << (TMR_W - 1);

  logic        clk, rst_n;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        apm_wr, apm_sel;
  logic [7:0]  apm_wdata, apm_rdata;
  logic        smi_en, pwr_btn;
  logic        sci, smi_pulse, shutdown_req, reset_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pm_event_unit #(.CLK_HZ(CLK_HZ), .TMR_HZ(TMR_HZ), .TMR_W(TMR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .apm_wr(apm_wr),
    .apm_sel(apm_sel), .apm_wdata(apm_wdata), .apm_rdata(apm_rdata),
    .smi_en(smi_en), .pwr_btn(pwr_btn), .sci(sci), .smi_pulse(smi_pulse),
    .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_acc, m_cnt, m_sts, m_en, m_ctl, m_apmc, m_apms;
  bit m_shut, m_rst, m_smi;

  always @(posedge clk or negedge rst_n) begin
    int set_b, clr_b, kind;
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_sts = 0; m_en = 0; m_ctl = 0;
      m_apmc = 0; m_apms = 0; m_shut = 0; m_rst = 0; m_smi = 0;
    end else begin
      set_b = 0; clr_b = 0;
      m_shut = 0; m_rst = 0; m_smi = 0;
      m_acc = m_acc + TMR_HZ;
      if (m_acc >= CLK_HZ) begin
        m_acc = m_acc - CLK_HZ;
        m_cnt = (m_cnt + 1) % TMR_MOD;
        if (m_cnt % HALF == 0) set_b = set_b | 1;
      end
      if (pwr_btn && ((m_en >> 8) & 1) == 1) set_b = set_b | 16'h0100;
      if (reg_wr) begin
        if (reg_addr == 6'h00) clr_b = int'(reg_wdata);
        else if (reg_addr == 6'h02) m_en = int'(reg_wdata);
        else if (reg_addr == 6'h04) begin
          m_ctl = int'(reg_wdata) & 16'hDFFF;
          if (reg_wdata[13]) begin
            kind = int'(reg_wdata[12:10]);
            if (kind == 0) m_shut = 1;
            else if (kind == 1) begin
              m_rst = 1;
              set_b = set_b | 16'h8100;
            end
          end
        end
      end
      if (apm_wr) begin
        if (!apm_sel) begin
          m_apmc = int'(apm_wdata);
          if (apm_wdata == 8'hF1) m_ctl = m_ctl | 1;
          if (apm_wdata == 8'hF0) m_ctl = m_ctl & 16'hFFFE;
          if (smi_en) m_smi = 1;
        end else m_apms = int'(apm_wdata);
      end
      m_sts = ((m_sts & ~clr_b) | set_b) & 16'hFFFF;
    end
  end

  // every-clock comparison of outputs
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (sci !== (((m_sts & m_en & 16'h0521) != 0) ? 1'b1 : 1'b0)) begin
        errors++;
        $display("FAIL R5 sci actual=%0b expected=%0b", sci, ((m_sts & m_en & 16'h0521) != 0));
      end
      checks++;
      if (shutdown_req !== m_shut || reset_req !== m_rst) begin
        errors++;
        $display("FAIL R8 shut/rst actual=%0b%0b expected=%0b%0b", shutdown_req, reset_req, m_shut, m_rst);
      end
      checks++;
      if (smi_pulse !== m_smi) begin
        errors++;
        $display("FAIL R10 smi actual=%0b expected=%0b", smi_pulse, m_smi);
      end
    end
  end

  function automatic int exp_read(input logic [5:0] a);
    case (a)
      6'h00: return m_sts;
      6'h02: return m_en;
      6'h04: return m_ctl;
      6'h08: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, int'(reg_rdata), exp_read(a));
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic apm(input logic sel, input logic [7:0] d);
    @(negedge clk);
    apm_wr = 1'b1; apm_sel = sel; apm_wdata = d;
    @(negedge clk);
    apm_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R1 watchdog actual=running expected=done");
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    apm_wr = 1'b0; apm_sel = 1'b0; apm_wdata = '0; smi_en = 1'b0; pwr_btn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(6'h00, "R11 status reset");
    rd(6'h02, "R11 enable reset");
    rd(6'h04, "R11 control reset");
    #1; chk("R11 apm cmd reset", int'(apm_rdata), 0);

    // R1 timer fractional rate
    idle(7);
    rd(6'h08, "R1 timer count");
    idle(5);
    rd(6'h08, "R1 timer count later");

    // R2 enable RW, unmapped offsets
    wr(6'h02, 16'hFFFF);
    rd(6'h02, "R2 enable all ones");
    wr(6'h06, 16'h1234);
    rd(6'h06, "R2 unmapped reads zero");
    rd(6'h02, "R2 unmapped write no effect");
    wr(6'h02, 16'h0001);

    // R4 first boundary
    idle(200);
    rd(6'h00, "R4 overflow set at mid boundary");
    chk("R4 status bit0", int'(reg_rdata[0]), 1);
    #1; chk("R5 sci with overflow enabled", int'(sci), 1);

    // R3 write-one-to-clear
    wr(6'h00, 16'h0000);
    rd(6'h00, "R3 zero write keeps");
    wr(6'h00, 16'h0001);
    rd(6'h00, "R3 one write clears");
    #1; chk("R5 sci low after clear", int'(sci), 0);

    // R4 wrap boundary sets again
    idle(200);
    rd(6'h00, "R4 overflow after wrap");
    chk("R4 rearmed bit0", int'(reg_rdata[0]), 1);
    wr(6'h00, 16'hFFFF);

    // R6 power button gated by enable
    @(negedge clk); pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
    rd(6'h00, "R6 button ignored when disabled");
    chk("R6 bit8 clear", int'(reg_rdata[8]), 0);
    wr(6'h02, 16'h0100);
    @(negedge clk); pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
    rd(6'h00, "R6 button latched");
    chk("R6 bit8 set", int'(reg_rdata[8]), 1);
    #1; chk("R5 sci from button", int'(sci), 1);
    wr(6'h00, 16'h0100);

    // R7 control store and strobe
    wr(6'h04, 16'h1C02);
    rd(6'h04, "R7 control stored no strobe");
    wr(6'h04, 16'h2C00);
    rd(6'h04, "R7 strobe bit not kept");
    // R8 sleep types
    wr(6'h04, 16'h2000);
    rd(6'h04, "R8 type0 control");
    wr(6'h04, 16'h2400);
    rd(6'h00, "R8 type1 sets wake and button");
    chk("R8 wake bit", int'(reg_rdata[15]), 1);
    wr(6'h00, 16'h8100);
    wr(6'h04, 16'h2800);
    rd(6'h00, "R8 type2 no effect");

    // R9 APM command codes
    apm(1'b0, 8'hF1);
    rd(6'h04, "R9 acpi enable");
    chk("R9 sci enable bit", int'(reg_rdata[0]), 1);
    #1; chk("R9 cmd readback", int'(apm_rdata), 8'hF1);
    apm(1'b0, 8'h55);
    rd(6'h04, "R9 other code keeps bit");
    apm(1'b0, 8'hF0);
    rd(6'h04, "R9 acpi disable");
    apm(1'b1, 8'hA5);
    #1; chk("R9 status byte", int'(apm_rdata), 8'hA5);
    apm_sel = 1'b0; #1;
    chk("R9 cmd unchanged by status write", int'(apm_rdata), 8'hF0);

    // R10 SMI permission
    smi_en = 1'b1;
    apm(1'b0, 8'h12);
    apm(1'b1, 8'h34);
    smi_en = 1'b0;
    apm(1'b0, 8'h56);
    idle(3);
    rd(6'h08, "R1 timer final");

    finish_run();
  end
endmodule